// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 46-bit virtual address into a 32-bit physical address by reading a three-level translation table out of memory. A requester presents the virtual address together with the page frame number of the top-level table. The block then issues three dependent 32-bit reads, one per level. Each read uses the frame number returned by the level above, except the first, which uses the supplied root frame. The block answers with a physical address, or with a fault if it meets an entry whose valid flag is clear.

Pages are 8 KB, so a table page holds 2048 four-byte entries. Each level therefore consumes 11 virtual address bits, and the low 13 bits pass through unchanged. Only one walk runs at a time. The memory side is a valid/ready request channel plus a response strobe carrying the read data.

Top module: `pt_walker`

## Requirements
- R1: After reset, and after any reset asserted in the middle of a walk, req_ready_o is 1 while mem_req_valid_o and resp_valid_o are 0.
- R2: The first read of a walk goes to address {root_pfn_i, va[45:35], 2'b00}.
- R3: The second read goes to {entry1[31:13], va[34:24], 2'b00} and the third to {entry2[31:13], va[23:13], 2'b00}, where entryN is the data returned by read N.
- R4: A walk whose three entries all have bit 0 set makes exactly three reads. It then pulses resp_valid_o for one cycle with resp_fault_o = 0 and resp_pa_o = {entry3[31:13], va[12:0]}.
- R5: An entry with bit 0 clear at any level ends the walk with no further reads. It gives one resp_valid_o pulse with resp_fault_o = 1 and resp_pa_o = 0.
- R6: req_ready_o is 0 from the cycle after a request is accepted until the cycle after the resp_valid_o pulse. A req_valid_i with a different address during that time has no effect on the read addresses or the result.
- R7: While mem_req_valid_o is 1 and mem_req_ready_i is 0, the request stays asserted and its address stays unchanged.
- R8: Entry bits [12:1] are ignored: they affect neither later read addresses nor the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request strobe |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_va_i | input | 46 | Virtual address to translate |
| root_pfn_i | input | 19 | Page frame number of the top-level table |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Byte address of the entry being read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Table entry returned by memory |
| resp_valid_o | output | 1 | One-cycle result strobe |
| resp_fault_o | output | 1 | Walk hit an invalid entry |
| resp_pa_o | output | 32 | Translated physical address, 0 on fault |

## Verification
The bench drives the all-zero and all-ones virtual addresses and mixed bit patterns, so a swapped or shifted index field shows up as a wrong entry address at one of the levels. It places invalid entries at each of the three levels. A walker that kept reading after a fault, or that reported a stale physical address, would show an extra read or a nonzero address. Entries carry junk in their low bits and some reads see a stalled memory port. This catches designs that let flag bits leak into the next frame number, or that drop or change a request before it is accepted. Some walks also see a second request in flight, which exposes a walker that relatches the virtual address while busy.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int VA_W   = 46,
  parameter int OFF_W  = 13,
  parameter int IDX_W  = 11,
  parameter int LEVELS = 3
) (
  input  logic [VA_W-1:0]                va_i,
  output logic [LEVELS-1:0][IDX_W-1:0]   idx_o,
  output logic [OFF_W-1:0]               off_o
);
  assign off_o = va_i[OFF_W-1:0];

  // idx_o[0] is the top level, taken from the highest bits
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign idx_o[g] = va_i[OFF_W + IDX_W*(LEVELS-1-g) +: IDX_W];
  end
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int PFN_W   = 19,
  parameter int IDX_W   = 11,
  parameter int ENTRY_B = 2,
  parameter int LEVELS  = 3,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int ADDR_W = PFN_W + IDX_W + ENTRY_B
) (
  input  logic [LEVELS-1:0][IDX_W-1:0] idx_i,
  input  logic [LVL_W-1:0]             lvl_i,
  input  logic [PFN_W-1:0]             table_pfn_i,
  output logic [ADDR_W-1:0]            addr_o
);
  logic [IDX_W-1:0] idx_sel;

  always_comb begin
    idx_sel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl_i == LVL_W'(i)) idx_sel = idx_i[i];
    end
  end

  assign addr_o = {table_pfn_i, idx_sel, {ENTRY_B{1'b0}}};
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int PTE_W  = 32,
  parameter int OFF_W  = 13,
  parameter int LEVELS = 3,
  localparam int PFN_W = PTE_W - OFF_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  output logic             accept_o,
  input  logic [PFN_W-1:0] root_pfn_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic [PFN_W-1:0] table_pfn_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output logic             resp_valid_o,
  output logic             resp_fault_o
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_st_e         st_q, st_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [PFN_W-1:0] pfn_q, pfn_d;
  logic             fault_q, fault_d;
  logic             entry_ok;

  assign entry_ok = mem_rsp_data_i[0];

  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    pfn_d   = pfn_q;
    fault_d = fault_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        st_d    = ST_REQ;
        lvl_d   = '0;
        pfn_d   = root_pfn_i;
        fault_d = 1'b0;
      end
      ST_REQ: if (mem_req_ready_i) st_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid_i) begin
        if (!entry_ok) begin
          fault_d = 1'b1;
          st_d    = ST_DONE;
        end else begin
          pfn_d = mem_rsp_data_i[PTE_W-1:OFF_W];
          if (lvl_q == LAST_LVL) begin
            st_d = ST_DONE;
          end else begin
            lvl_d = lvl_q + 1'b1;
            st_d  = ST_REQ;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      pfn_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      lvl_q   <= lvl_d;
      pfn_q   <= pfn_d;
      fault_q <= fault_d;
    end
  end

  assign req_ready_o     = (st_q == ST_IDLE);
  assign accept_o        = req_ready_o && req_valid_i;
  assign mem_req_valid_o = (st_q == ST_REQ);
  assign resp_valid_o    = (st_q == ST_DONE);
  assign resp_fault_o    = resp_valid_o && fault_q;
  assign lvl_o           = lvl_q;
  assign table_pfn_o     = pfn_q;

  a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(lvl_o) && $stable(table_pfn_o));

  a_r4_resp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o && req_ready_o);

  a_r5_fault_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_fault_o |-> $past(mem_rsp_valid_i) && !$past(mem_rsp_data_i[0]));

  a_r3_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> lvl_o <= LAST_LVL);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W    = 46,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 13,
  parameter int LEVELS  = 3,
  parameter int ENTRY_B = 2,
  localparam int IDX_W  = OFF_W - ENTRY_B,
  localparam int PFN_W  = PA_W - OFF_W,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [PFN_W-1:0]  root_pfn_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [PA_W-1:0]   mem_rsp_data_i,
  output logic              resp_valid_o,
  output logic              resp_fault_o,
  output logic [PA_W-1:0]   resp_pa_o
);
  logic                         accept;
  logic [VA_W-1:0]              va_q;
  logic [LEVELS-1:0][IDX_W-1:0] idx;
  logic [OFF_W-1:0]             off;
  logic [LVL_W-1:0]             lvl;
  logic [PFN_W-1:0]             table_pfn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     va_q <= '0;
    else if (accept) va_q <= req_va_i;
  end

  pt_va_split #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
  ) u_split (
    .va_i (va_q),
    .idx_o(idx),
    .off_o(off)
  );

  pt_entry_addr #(
    .PFN_W(PFN_W), .IDX_W(IDX_W), .ENTRY_B(ENTRY_B), .LEVELS(LEVELS)
  ) u_addr (
    .idx_i      (idx),
    .lvl_i      (lvl),
    .table_pfn_i(table_pfn),
    .addr_o     (mem_req_addr_o)
  );

  pt_walk_ctrl #(
    .PTE_W(PA_W), .OFF_W(OFF_W), .LEVELS(LEVELS)
  ) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .accept_o       (accept),
    .root_pfn_i     (root_pfn_i),
    .lvl_o          (lvl),
    .table_pfn_o    (table_pfn),
    .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i (mem_rsp_data_i),
    .resp_valid_o   (resp_valid_o),
    .resp_fault_o   (resp_fault_o)
  );

  // table_pfn holds the last frame number once the walk is done
  assign resp_pa_o = (resp_valid_o && !resp_fault_o) ? {table_pfn, off} : '0;

  a_r6_va_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(va_q));

  a_r6_busy_during_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o || resp_valid_o) |-> !req_ready_o);

  a_r5_fault_zero_pa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_fault_o |-> resp_valid_o && resp_pa_o == '0);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  typedef struct packed {
    logic [45:0] va;
    logic [18:0] root;
    logic [31:0] e0;
    logic [31:0] e1;
    logic [31:0] e2;
    logic [3:0]  stall;
    logic        busy;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{46'h0000_0000_0000, 19'h00001, 32'h0000_2001, 32'h0000_4001, 32'h0000_6001, 4'd0, 1'b0},
    '{46'h3FFF_FFFF_FFFF, 19'h7FFFF, 32'hFFFF_E001, 32'hAAAA_A001, 32'h5555_5FFF, 4'd2, 1'b1},
    '{46'h1234_5678_9ABC, 19'h12345, 32'h0ABC_E001, 32'h0000_0000, 32'h1111_3001, 4'd0, 1'b0},
    '{46'h0F0F_0F0F_0F0F, 19'h0ABCD, 32'hFFFF_FFFE, 32'h2222_2001, 32'h3333_3001, 4'd1, 1'b0},
    '{46'h2AAA_AAAA_AAAA, 19'h55555, 32'h8000_1FFF, 32'h7FFF_E003, 32'hC0DE_2001, 4'd3, 1'b1},
    '{46'h1555_5555_5555, 19'h0F00F, 32'h4444_4001, 32'h9876_5001, 32'h1234_5FFE, 4'd0, 1'b1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [45:0] req_va_i = '0;
  logic [18:0] root_pfn_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        resp_valid_o;
  logic        resp_fault_o;
  logic [31:0] resp_pa_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  pt_walker u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_va_i(req_va_i), .root_pfn_i(root_pfn_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .resp_valid_o(resp_valid_o), .resp_fault_o(resp_fault_o), .resp_pa_o(resp_pa_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int lvl, input logic [45:0] va,
                                           input logic [18:0] root, input logic [31:0] e [3]);
    logic [18:0] pfn;
    logic [10:0] idx;
    pfn = (lvl == 0) ? root : e[lvl-1][31:13];
    idx = 11'((va >> (13 + 11 * (2 - lvl))) & 46'h7FF);
    return {pfn, idx, 2'b00};
  endfunction

  task automatic check_idle(input string req);
    check({req, " ready"}, 64'(req_ready_o), 64'd1);
    check({req, " mem_req_valid"}, 64'(mem_req_valid_o), 64'd0);
    check({req, " resp_valid"}, 64'(resp_valid_o), 64'd0);
  endtask

  task automatic run_walk(input vec_t v);
    logic [31:0] e [3];
    logic [31:0] held;
    int nreads, exp_reads;
    logic exp_fault, done;
    e[0] = v.e0; e[1] = v.e1; e[2] = v.e2;
    exp_reads = 3; exp_fault = 1'b0;
    for (int l = 2; l >= 0; l--) if (!e[l][0]) begin exp_reads = l + 1; exp_fault = 1'b1; end
    @(negedge clk_i);
    req_valid_i = 1'b1; req_va_i = v.va; root_pfn_i = v.root;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R6 ready low after accept", 64'(req_ready_o), 64'd0);
    if (v.busy) begin
      req_valid_i = 1'b1; req_va_i = ~v.va; root_pfn_i = ~v.root;
    end
    nreads = 0; done = 1'b0;
    for (int it = 0; it < 60 && !done; it++) begin
      if (it > 0) @(negedge clk_i);
      mem_rsp_valid_i = 1'b0;
      if (resp_valid_o) begin
        done = 1'b1;
        req_valid_i = 1'b0;
        check("R4/R5 read count", 64'(nreads), 64'(exp_reads));
        check("R4/R5 fault flag", 64'(resp_fault_o), 64'(exp_fault));
        check("R4/R5/R8 physical address", 64'(resp_pa_o),
              exp_fault ? 64'd0 : 64'({e[2][31:13], v.va[12:0]}));
      end else if (mem_req_valid_o) begin
        if (nreads < 3)
          check(nreads == 0 ? "R2 level-1 address" : "R3/R8 next-level address",
                64'(mem_req_addr_o), 64'(exp_addr(nreads, v.va, v.root, e)));
        held = mem_req_addr_o;
        for (int s = 0; s < int'(v.stall); s++) begin
          @(negedge clk_i);
          check("R7 request held", 64'(mem_req_valid_o), 64'd1);
          check("R7 address stable", 64'(mem_req_addr_o), 64'(held));
        end
        mem_req_ready_i = 1'b1;
        @(negedge clk_i);
        mem_req_ready_i = 1'b0;
        check("R6 ready low while busy", 64'(req_ready_o), 64'd0);
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i = (nreads < 3) ? e[nreads] : 32'h0;
        nreads++;
      end
    end
    if (!done) check("R4 walk completes", 64'd0, 64'd1);
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check("R4 resp one-cycle pulse", 64'(resp_valid_o), 64'd0);
    check("R6 ready after result", 64'(req_ready_o), 64'd1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_idle("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1 after release");

    for (int i = 0; i < NV; i++) run_walk(VECS[i]);

    // R1: reset in the middle of a walk
    @(negedge clk_i);
    req_valid_i = 1'b1; req_va_i = 46'h0123_4567_89AB; root_pfn_i = 19'h00042;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R1 walk started", 64'(mem_req_valid_o), 64'd1);
    #2 rst_ni = 1'b0;
    #1 check_idle("R1 mid-walk reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1 mid-walk reset release");

    // walk after recovery, valid entries with junk low bits (R8)
    run_walk('{46'h3C3C_3C3C_3C3C, 19'h1ABCD, 32'h0246_9FFF, 32'h1357_BFFF, 32'hFEDC_BFFF, 4'd1, 1'b0});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule